// File: doc/BRIEF.md
# Write-Once Software Watchdog Timer

This block is a watchdog counter that software has to service at regular intervals. A prescaler divides the input clock down to a tick, and each tick decrements a down-counter. If software lets the counter run past zero, the block signals a timeout. The timeout raises either a one-cycle system reset request or a sticky non-maskable interrupt.

A single protection control word holds four settings: the enable, the timeout action, a 2-bit period select and a freeze-halt bit. The block leaves reset already enabled at its longest period with the reset action chosen. Software gets exactly one write to the control word. After that write the word is locked until the next reset. Software services the watchdog by writing two key values in order to the service address. It reads the control word with the lock flag, the live count and the NMI status through the same register port.

Top module: `wdog_top`

## Requirements
- R1: After reset, `rst_req` and `nmi` are low and the control readback at address 0 is 16'h000D. In that value bit0 is enable=1, bit1 is action=0 (reset), bits 3:2 are the period select=2'b11, bit4 is freeze-halt=0 and bit15 is the lock flag=0. The count readback at address 1 equals RELOAD.
- R2: A timeout occurs (RELOAD+1)·2^TAPn clock cycles after the counter was last reloaded. TAPn is TAP0..TAP3, chosen by period select 0..3.
- R3: With action=0, a timeout drives `rst_req` high for exactly one cycle and never raises `nmi`.
- R4: With action=1 (bit1), a timeout sets `nmi`. It stays high until a write to address 2 with data bit0=1 clears it. `rst_req` stays low.
- R5: The first write to address 0 loads bits 4:0 and sets the lock flag (readback bit15). Every later write to address 0 is ignored until reset.
- R6: Writing 16'h556C and then 16'hAA39 to address 1 reloads the counter and prescaler. If any other value is written to address 1 between them, the sequence is abandoned and no reload occurs.
- R7: With enable=0, no timeout is produced, and the count stays at RELOAD.
- R8: With freeze-halt=1, the prescaler and counter stop while `freeze` is high. With freeze-halt=0, they keep running.
- R9: `rd_data` is registered and shows the word chosen by `rd_addr` one clock after it is presented. Address 0 gives the control word, address 1 the count and address 2 the NMI flag in bit0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 service, 2 status) |
| wr_data | input | DW | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DW | Registered read data |
| freeze | input | 1 | Debug freeze request |
| rst_req | output | 1 | One-cycle system reset request |
| nmi | output | 1 | Sticky non-maskable interrupt |

## Verification
The bench measures the exact number of cycles from a reload to the timeout for every period select. A tap off by one bit would change the count by a factor of two, and an off-by-one in the counter would add or drop a whole tick period. It tries to rewrite the control word after locking it. A design without the lock would then disable itself and never time out. It breaks the key sequence with a stray value, which a design that only checks the second key would wrongly accept. It also holds freeze with and without the halt bit, which catches a design that ignores the halt bit or always halts. Finally it clears the NMI flag between two timeouts, which shows whether the flag is truly sticky and truly clearable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic       frz_halt;
    logic [1:0] sel;
    logic       act_nmi;
    logic       en;
  } wd_ctrl_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_SVC  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam wd_ctrl_t CTRL_RST = '{frz_halt: 1'b0, sel: 2'b11, act_nmi: 1'b0, en: 1'b1};

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [4:0] wr_bits,
  output wd_ctrl_t   ctrl,
  output logic       locked
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= CTRL_RST;
      locked <= 1'b0;
    end else if (wr_en && wr_addr == A_CTRL && !locked) begin
      ctrl   <= wr_bits;
      locked <= 1'b1;
    end
  end

  // R5: once locked, the control word never changes until reset
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(ctrl));

endmodule

// File: rtl/wdog_svc.sv
module wdog_svc
  import wdog_pkg::*;
#(
  parameter int          DW   = 16,
  parameter logic [15:0] KEY1 = 16'h556C,
  parameter logic [15:0] KEY2 = 16'hAA39
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          svc_ok
);

  logic armed;
  logic svc_wr;

  assign svc_wr = wr_en && (wr_addr == A_SVC);
  assign svc_ok = svc_wr && armed && (wr_data == DW'(KEY2));

  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (svc_wr)
      armed <= (wr_data == DW'(KEY1));
  end

  // R6: a completed service leaves the sequence disarmed
  p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
    svc_ok |=> !armed);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int RELOAD = 255,
  parameter int TAP0   = 9,
  parameter int TAP1   = 13,
  parameter int TAP2   = 17,
  parameter int TAP3   = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  wd_ctrl_t         ctrl,
  input  logic             freeze,
  input  logic             reload,
  input  logic             clr_nmi,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_req,
  output logic             nmi
);

  localparam int TAPS [4] = '{TAP0, TAP1, TAP2, TAP3};
  localparam int PW01 = (TAP0 > TAP1) ? TAP0 : TAP1;
  localparam int PW23 = (TAP2 > TAP3) ? TAP2 : TAP3;
  localparam int PW   = (PW01 > PW23) ? PW01 : PW23;
  localparam logic [CNT_W-1:0] RLD = CNT_W'(RELOAD);

  logic [PW-1:0] tap_mask [4];
  logic [PW-1:0] presc;
  logic          running;
  logic          tick;
  logic          timeout;

  for (genvar g = 0; g < 4; g++) begin : g_tap
    localparam logic [PW:0] FULL = ({{PW{1'b0}}, 1'b1} << TAPS[g]) - 1'b1;
    assign tap_mask[g] = FULL[PW-1:0];
  end

  assign running = ctrl.en && !(ctrl.frz_halt && freeze);
  assign tick    = running && ((presc & tap_mask[ctrl.sel]) == tap_mask[ctrl.sel]);
  assign timeout = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      presc   <= '0;
      cnt     <= RLD;
      rst_req <= 1'b0;
      nmi     <= 1'b0;
    end else begin
      rst_req <= timeout && !ctrl.act_nmi;
      if (timeout && ctrl.act_nmi)
        nmi <= 1'b1;
      else if (clr_nmi)
        nmi <= 1'b0;
      if (!ctrl.en || reload) begin
        presc <= '0;
        cnt   <= RLD;
      end else if (running) begin
        presc <= presc + 1'b1;
        if (tick)
          cnt <= (cnt == '0) ? RLD : cnt - 1'b1;
      end
    end
  end

  // R2: the count never leaves its reload range
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= RLD);
  // R3: reset request is a single-cycle pulse
  p_rst_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R4: NMI holds until cleared
  p_nmi_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (nmi && !clr_nmi) |=> nmi);
  // R6: a service leaves the count at its reload value
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    reload |=> cnt == RLD);
  // R7: a disabled watchdog raises no reset request
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |=> !rst_req);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int          DW     = 16,
  parameter int          CNT_W  = 8,
  parameter int          RELOAD = 255,
  parameter int          TAP0   = 9,
  parameter int          TAP1   = 13,
  parameter int          TAP2   = 17,
  parameter int          TAP3   = 21,
  parameter logic [15:0] KEY1   = 16'h556C,
  parameter logic [15:0] KEY2   = 16'hAA39
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          freeze,
  output logic          rst_req,
  output logic          nmi
);

  localparam int CW = $bits(wd_ctrl_t);

  wd_ctrl_t         ctrl;
  logic             locked;
  logic             svc_ok;
  logic             clr_nmi;
  logic [CNT_W-1:0] cnt;

  assign clr_nmi = wr_en && (wr_addr == A_STAT) && wr_data[0];

  wdog_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bits (wr_data[CW-1:0]),
    .ctrl    (ctrl),
    .locked  (locked)
  );

  wdog_svc #(.DW(DW), .KEY1(KEY1), .KEY2(KEY2)) u_svc (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .svc_ok  (svc_ok)
  );

  wdog_core #(
    .CNT_W(CNT_W), .RELOAD(RELOAD),
    .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .freeze  (freeze),
    .reload  (svc_ok),
    .clr_nmi (clr_nmi),
    .cnt     (cnt),
    .rst_req (rst_req),
    .nmi     (nmi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_CTRL:  rd_data <= {locked, {(DW-1-CW){1'b0}}, ctrl};
        A_SVC:   rd_data <= {{(DW-CNT_W){1'b0}}, cnt};
        A_STAT:  rd_data <= {{(DW-1){1'b0}}, nmi};
        default: rd_data <= '0;
      endcase
    end
  end

  // R5: the lock flag never falls outside reset
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

endmodule

// File: tb/wdog_top_tb.sv
module wdog_top_tb;

  localparam int TB_RELOAD = 3;
  localparam int NVEC = 4;
  localparam int VEC_SEL [NVEC] = '{0, 1, 2, 3};
  localparam int VEC_EXP [NVEC] = '{16, 32, 64, 128};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        freeze = 1'b0;
  logic        rst_req;
  logic        nmi;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit saw_rst = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_req) saw_rst = 1;

  wdog_top #(.CNT_W(4), .RELOAD(TB_RELOAD), .TAP0(2), .TAP1(3), .TAP2(4), .TAP3(5)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .freeze(freeze), .rst_req(rst_req), .nmi(nmi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    saw_rst = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic service();
    wr(2'd1, 16'h556C);
    wr(2'd1, 16'hAA39);
  endtask

  // cycles from t0 until the chosen output is seen high
  task automatic wait_out(input bit use_nmi, input int t0, output int n);
    while (!(use_nmi ? nmi : rst_req) && (cyc - t0) < 3000) @(negedge clk);
    n = cyc - t0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int v, t0, n;
    // R1 / R9: reset state and readback map
    do_reset();
    chk(rst_req == 1'b0 && nmi == 1'b0, "R1 outputs idle", int'({rst_req, nmi}), 0);
    rd(2'd0, v); chk(v == 16'h000D, "R1 R9 ctrl readback", v, 16'h000D);
    rd(2'd1, v); chk(v == TB_RELOAD, "R1 R9 count readback", v, TB_RELOAD);
    rd(2'd2, v); chk(v == 0, "R9 status readback", v, 0);

    // R1 R3: default armed at longest period, reset action
    do_reset();
    t0 = cyc;
    wait_out(1'b0, t0, n);
    chk(n == 128, "R1 R2 default timeout", n, 128);
    @(negedge clk);
    chk(rst_req == 1'b0, "R3 pulse width", int'(rst_req), 0);
    chk(nmi == 1'b0, "R3 no nmi", int'(nmi), 0);

    // R2: period table walk
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      wr(2'd0, 16'(1 | (VEC_SEL[i] << 2)));
      service();
      t0 = cyc;
      wait_out(1'b0, t0, n);
      chk(n == VEC_EXP[i], "R2 period select", n, VEC_EXP[i]);
    end

    // R4 R5: NMI mode, lock against a second write
    do_reset();
    wr(2'd0, 16'h0003);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); chk(v == 16'h8003, "R5 lock and ignored rewrite", v, 16'h8003);
    service();
    t0 = cyc;
    wait_out(1'b1, t0, n);
    chk(n == 16, "R4 nmi timeout", n, 16);
    repeat (40) @(negedge clk);
    chk(nmi == 1'b1, "R4 nmi sticky", int'(nmi), 1);
    rd(2'd2, v); chk(v == 1, "R4 R9 status flag", v, 1);
    wr(2'd2, 16'h0001);
    chk(nmi == 1'b0, "R4 nmi cleared", int'(nmi), 0);
    chk(saw_rst == 1'b0, "R4 no reset request", int'(saw_rst), 0);

    // R7: disabled
    do_reset();
    wr(2'd0, 16'h0000);
    repeat (300) @(negedge clk);
    chk(saw_rst == 1'b0 && nmi == 1'b0, "R7 disabled quiet", int'({saw_rst, nmi}), 0);
    rd(2'd1, v); chk(v == TB_RELOAD, "R7 count held", v, TB_RELOAD);

    // R6: broken key sequence does not reload
    do_reset();
    wr(2'd0, 16'h0001);
    service();
    t0 = cyc;
    wr(2'd1, 16'h556C);
    wr(2'd1, 16'h1234);
    wr(2'd1, 16'hAA39);
    wait_out(1'b0, t0, n);
    chk(n == 16, "R6 broken sequence ignored", n, 16);

    // R6: valid service restarts the period
    do_reset();
    wr(2'd0, 16'h0001);
    service();
    repeat (5) @(negedge clk);
    service();
    t0 = cyc;
    wait_out(1'b0, t0, n);
    chk(n == 16, "R6 service reloads", n, 16);

    // R8: freeze halts with halt bit set
    do_reset();
    wr(2'd0, 16'h0011);
    service();
    t0 = cyc;
    freeze = 1'b1;
    repeat (50) @(negedge clk);
    freeze = 1'b0;
    wait_out(1'b0, t0, n);
    chk(n == 66, "R8 freeze halts", n, 66);

    // R8: freeze ignored with halt bit clear
    do_reset();
    wr(2'd0, 16'h0001);
    service();
    t0 = cyc;
    freeze = 1'b1;
    wait_out(1'b0, t0, n);
    freeze = 1'b0;
    chk(n == 16, "R8 freeze ignored", n, 16);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule